// File: doc/BRIEF.md
# Three-in-a-row ones detector

This block watches a one-bit serial stream, one bit per clock, and raises a single-cycle flag when it sees the third 1 of an unbroken run. A two-bit state register counts how many 1s have arrived in a row: none, one or two. Combinational logic computes the next count and the flag from the present count and the live input. Any 0 clears the count.

The flag is Mealy-style. It goes high during the same cycle in which the third 1 is on the input, before that bit is clocked in. Matches do not overlap. The clock edge that takes in the third 1 also returns the count to zero, so a fourth 1 counts as the first of a new run. A run of six 1s therefore fires on the third and sixth bits only.

Reset is asynchronous and active low. The block releases it internally through a short synchronizer, so the count leaves its reset value only on a clean clock edge.

Top module: `seq3_detect`

## Requirements
- R1: While `rst_n` is low, `match` is 0 whatever `din` is. After reset the count is zero: three 1s applied after reset release fire `match` on the third, and not before.
- R2: A 0 on `din` holds `match` at 0 in that cycle and clears the count at the next rising edge, whatever the count was.
- R3: From a count of zero, a 1 raises the count to one with `match` at 0. From a count of one, a 1 raises it to two with `match` at 0.
- R4: With a count of two, a 1 on `din` drives `match` to 1 combinationally, in the same cycle, before the next rising edge.
- R5: The rising edge that takes in the third 1 returns the count to zero, so matches never overlap. For six 1s in a row, `match` is 1 on the 3rd and 6th bits only.
- R6: `din` is sampled only at the rising edge of `clk`. A pulse on `din` that starts and ends between two rising edges leaves the count unchanged.
- R7: Asserting `rst_n` low in the middle of a run clears the count at once. After release, a run of 1s must start again from zero.
- R8: Over a long random stream, `match` equals, cycle by cycle, the output of a counter model that counts consecutive 1s and wraps to zero on the third one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din | input | 1 | Serial data bit, sampled at each rising edge |
| match | output | 1 | High in the cycle in which the third consecutive 1 is present on `din` |

## Verification
A wrong count shows on `match` within at most three input bits.

- A count that is too high fires `match` on the first or second 1 of a run.
- A count that is too low, or one that fails to clear after a match, moves the pulse to a later bit or repeats it on the fourth 1.
- A count that ignores a 0 joins two separate runs into one match.

Since every such fault changes `match` within a few cycles, the bench compares `match` just before each rising edge, with directed runs and a long random stream.

// File: rtl/seq3_pkg.sv
`timescale 1ns/1ps
package seq3_pkg;
  localparam int STATE_W = 2;

  // Count of consecutive 1s seen so far; encoding 2'b11 is never used.
  typedef enum logic [STATE_W-1:0] {
    RUN_NONE = 2'b00,
    RUN_ONE  = 2'b01,
    RUN_TWO  = 2'b10
  } run_state_e;
endpackage

// File: rtl/seq3_rst_sync.sv
`timescale 1ns/1ps
module seq3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq3_next_state.sv
`timescale 1ns/1ps
module seq3_next_state
  import seq3_pkg::*;
(
  input  run_state_e state_q,
  input  logic       din,
  output run_state_e state_d,
  output logic       hit
);
  always_comb begin
    state_d = RUN_NONE;
    hit     = 1'b0;
    unique case (state_q)
      RUN_NONE: state_d = din ? RUN_ONE : RUN_NONE;
      RUN_ONE:  state_d = din ? RUN_TWO : RUN_NONE;
      RUN_TWO: begin
        state_d = RUN_NONE;
        hit     = din;
      end
      default: begin
        state_d = RUN_NONE;
        hit     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/seq3_state_reg.sv
`timescale 1ns/1ps
module seq3_state_reg
  import seq3_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  run_state_e state_d,
  output run_state_e state_q
);
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= RUN_NONE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/seq3_detect.sv
`timescale 1ns/1ps
module seq3_detect
  import seq3_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic match
);
  logic       srst_n;
  run_state_e state_q;
  run_state_e state_d;

  seq3_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  seq3_next_state next_i (
    .state_q(state_q),
    .din    (din),
    .state_d(state_d),
    .hit    (match)
  );

  seq3_state_reg reg_i (
    .clk    (clk),
    .srst_n (srst_n),
    .state_d(state_d),
    .state_q(state_q)
  );

  // R2
  zero_clears_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !din |=> state_q == RUN_NONE);

  // R3
  first_one_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == RUN_NONE && din) |=> state_q == RUN_ONE);

  // R3
  two_from_one_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == RUN_TWO) |-> ($past(state_q) == RUN_ONE && $past(din)));

  // R5
  match_restarts_chk: assert property (@(posedge clk) disable iff (!srst_n)
    match |=> (state_q == RUN_NONE && !match));

  // R4
  match_needs_run_chk: assert property (@(posedge clk) disable iff (!srst_n)
    match |-> ($past(state_q) == RUN_ONE && $past(din) && din));

  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!srst_n)
    state_q != run_state_e'(2'b11));
endmodule

// File: tb/seq3_detect_tb.sv
`timescale 1ns/1ps
module seq3_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic match;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  seq3_detect dut_i (.clk(clk), .rst_n(rst_n), .din(din), .match(match));

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (match !== exp) begin
      n_bad++;
      $display("FAIL %s: match=%b expected=%b at %0t", req, match, exp, $time);
    end
  endtask

  // Drive one bit after a falling edge, then compare before the rising edge.
  task automatic apply(input logic b, input logic exp, input string req);
    @(negedge clk);
    din = b;
    #1;
    check(exp, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din   = 1'b1;
    #1;
    check(1'b0, "R1");
    repeat (2) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    din   = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_after_reset();
    do_reset();
    apply(1'b1, 1'b0, "R1");
    apply(1'b1, 1'b0, "R3");
    apply(1'b1, 1'b1, "R1");
    apply(1'b0, 1'b0, "R2");
  endtask

  task automatic t_zero_breaks();
    apply(1'b1, 1'b0, "R3");
    apply(1'b0, 1'b0, "R2");
    apply(1'b1, 1'b0, "R3");
    apply(1'b1, 1'b0, "R3");
    apply(1'b0, 1'b0, "R2");
    apply(1'b1, 1'b0, "R2");
    apply(1'b1, 1'b0, "R2");
    apply(1'b1, 1'b1, "R4");
    apply(1'b0, 1'b0, "R2");
  endtask

  task automatic t_six_ones();
    for (int i = 1; i <= 6; i++)
      apply(1'b1, (i % 3 == 0), "R5");
    apply(1'b0, 1'b0, "R5");
  endtask

  task automatic t_glitch();
    // A 1 pulse between edges must not count.
    @(negedge clk);
    din = 1'b1;
    #0.5 din = 1'b0;
    #1 check(1'b0, "R6");
    apply(1'b1, 1'b0, "R6");
    apply(1'b1, 1'b0, "R6");
    // A 0 pulse between edges must not clear a count of two.
    @(negedge clk);
    din = 1'b0;
    #0.5 din = 1'b1;
    #0.5 check(1'b1, "R6");
    apply(1'b0, 1'b0, "R6");
  endtask

  task automatic t_mid_reset();
    apply(1'b1, 1'b0, "R7");
    apply(1'b1, 1'b0, "R7");
    do_reset();
    apply(1'b1, 1'b0, "R7");
    apply(1'b1, 1'b0, "R7");
    apply(1'b1, 1'b1, "R7");
    apply(1'b0, 1'b0, "R7");
  endtask

  task automatic t_random();
    int run = 0;
    logic b;
    logic exp;
    void'($urandom(32'd12345));
    for (int i = 0; i < 1500; i++) begin
      b = ($urandom_range(0, 3) != 0);
      exp = 1'b0;
      if (b) begin
        if (run == 2) begin exp = 1'b1; run = 0; end
        else run++;
      end else run = 0;
      apply(b, exp, "R8");
    end
    apply(1'b0, 1'b0, "R8");
  endtask

  initial begin
    t_after_reset();
    t_zero_breaks();
    t_six_ones();
    t_glitch();
    t_mid_reset();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule